// File: doc/BRIEF.md
# SD Card Bus Clock Generator

This block derives the card bus clock from a faster master clock (nominally 72 MHz). An 8-bit divide setting selects a card clock of master / (setting + 2). A bypass control passes the master clock straight through instead. A clock-enable bit and a power-save bit decide when the card clock may run. With power-save set, the clock runs only while the command or data path reports that the bus is busy.

Next to the card clock, the block gives two single-master-cycle strobes, one for the drive edge and one for the sample edge. The command and data paths use them to do all their work in the master clock domain. An edge-select bit sets which card-clock edge is the drive edge and which is the sample edge.

Top module: `sdclk_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `card_clk`, `drive_stb` and `sample_stb` are low.
- R2: With bypass clear and the clock running, successive rising edges of `card_clk` are exactly `div_val` + 2 master cycles apart, for every `div_val` from 0 to 255.
- R3: In divided mode the high phase of each card-clock period lasts floor((`div_val`+2)/2) master cycles. The low phase lasts the rest of the period.
- R4: A change to `div_val` in the middle of a period does not alter that period. The new value governs the next period, counted from its rising edge.
- R5: When `clk_en` is low, the period in progress completes. After that, `card_clk` stays low and neither strobe fires.
- R6: With `pwr_save` high, the card clock stops (low, no strobes) while `bus_busy` is low. It runs with the normal period while `bus_busy` is high. With `pwr_save` low, `bus_busy` has no effect.
- R7: With `bypass` high and the clock enabled, `card_clk` follows the master clock (high in its high phase, low in its low phase) whatever `div_val` holds. Both strobes are high in every cycle.
- R8: With `edge_sel` = 0, `sample_stb` marks card-clock rising edges and `drive_stb` marks falling edges. With `edge_sel` = 1, the two roles are swapped.
- R9: In divided mode, each strobe is high for exactly one master cycle per edge. That cycle is the first master cycle in which `card_clk` shows its new level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| div_val | input | 8 | Divide setting; card period = div_val + 2 master cycles |
| bypass | input | 1 | Pass the master clock straight to the card |
| pwr_save | input | 1 | Run the card clock only while the bus is busy |
| clk_en | input | 1 | Card clock enable |
| edge_sel | input | 1 | 0: drive on falling, sample on rising; 1: the reverse |
| bus_busy | input | 1 | Bus activity from the command and data paths |
| card_clk | output | 1 | Card bus clock |
| drive_stb | output | 1 | One-cycle strobe at the card-clock drive edge |
| sample_stb | output | 1 | One-cycle strobe at the card-clock sample edge |

## Verification
The hardest case to reach is a divide change that lands inside a running period. The bench waits for a card-clock rising edge that the monitor reports. Two master cycles later it rewrites the setting, and it expects the old period to finish whole before the new one begins. The move between divided and bypass mode is also hard to reach. The bench stops the clock first, enables bypass with an unrelated divide value, probes both phases of the master clock, and then returns to divided mode to confirm that the divider restarts cleanly.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

  // High-phase length of a card clock period, in master cycles.
  function automatic logic [8:0] high_len(input logic [8:0] period);
    return period >> 1;
  endfunction

  typedef enum logic {
    DRIVE_ON_FALL = 1'b0,
    DRIVE_ON_RISE = 1'b1
  } edge_map_e;

endpackage

// File: rtl/sdclk_divider.sv
module sdclk_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_val,
  input  logic             run,
  output logic             div_clk,
  output logic             rise_pulse,
  output logic             fall_pulse,
  output logic             idle
);
  import sdclk_pkg::*;

  localparam int CNT_W = DIV_W + 1;

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] per_q;
  logic [CNT_W-1:0] hi_q;
  logic             clk_q;
  logic             rise_q;
  logic             fall_q;

  logic [CNT_W-1:0] new_per;
  logic [CNT_W-1:0] nxt_cnt;
  logic             boundary;
  logic             nxt_high;

  assign new_per  = {1'b0, div_val} + CNT_W'(2);
  assign nxt_cnt  = cnt_q + CNT_W'(1);
  assign boundary = !active_q || (cnt_q == per_q - CNT_W'(1));
  assign nxt_high = nxt_cnt < hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      per_q    <= CNT_W'(2);
      hi_q     <= CNT_W'(1);
      clk_q    <= 1'b0;
      rise_q   <= 1'b0;
      fall_q   <= 1'b0;
    end else begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      if (boundary) begin
        cnt_q <= '0;
        if (run) begin
          active_q <= 1'b1;
          per_q    <= new_per;
          hi_q     <= high_len(new_per);
          clk_q    <= 1'b1;
          rise_q   <= 1'b1;
        end else begin
          active_q <= 1'b0;
          clk_q    <= 1'b0;
        end
      end else begin
        cnt_q  <= nxt_cnt;
        clk_q  <= nxt_high;
        fall_q <= clk_q && !nxt_high;
      end
    end
  end

  assign div_clk    = clk_q;
  assign rise_pulse = rise_q;
  assign fall_pulse = fall_q;
  assign idle       = !active_q;

  a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    active_q |-> (cnt_q < per_q));

  a_r4_per_hold: assert property (@(posedge clk) disable iff (rst)
    (active_q && !boundary) |=> $stable(per_q));

  a_r5_idle_low: assert property (@(posedge clk) disable iff (rst)
    !active_q |-> !clk_q);

  a_r9_rise_with_clk: assert property (@(posedge clk) disable iff (rst)
    rise_q |-> (clk_q && cnt_q == '0));

endmodule

// File: rtl/sdclk_gate.sv
module sdclk_gate (
  input  logic clk,
  input  logic rst,
  input  logic bypass,
  input  logic pwr_save,
  input  logic clk_en,
  input  logic bus_busy,
  input  logic div_idle,
  output logic div_run,
  output logic byp_on
);
  logic want;
  logic byp_q;

  assign want    = clk_en && (!pwr_save || bus_busy);
  assign div_run = want && !bypass && !byp_q;

  // Updated on the falling master edge so the pass-through gate never
  // changes while the master clock is high.
  always_ff @(negedge clk) begin
    if (rst) byp_q <= 1'b0;
    else     byp_q <= want && bypass && (div_idle || byp_q);
  end

  assign byp_on = byp_q;

  a_r7_bypass_excl: assert property (@(posedge clk) disable iff (rst)
    byp_q |-> div_idle);

endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_val,
  input  logic             bypass,
  input  logic             pwr_save,
  input  logic             clk_en,
  input  logic             edge_sel,
  input  logic             bus_busy,
  output logic             card_clk,
  output logic             drive_stb,
  output logic             sample_stb
);
  import sdclk_pkg::*;

  logic div_clk, rise_p, fall_p, div_idle, div_run, byp_on;
  edge_map_e emap;

  sdclk_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .div_val(div_val), .run(div_run),
    .div_clk(div_clk), .rise_pulse(rise_p), .fall_pulse(fall_p), .idle(div_idle)
  );

  sdclk_gate u_gate (
    .clk(clk), .rst(rst), .bypass(bypass), .pwr_save(pwr_save),
    .clk_en(clk_en), .bus_busy(bus_busy), .div_idle(div_idle),
    .div_run(div_run), .byp_on(byp_on)
  );

  assign emap       = edge_map_e'(edge_sel);
  assign card_clk   = (clk && byp_on) || div_clk;
  assign drive_stb  = byp_on || ((emap == DRIVE_ON_RISE) ? rise_p : fall_p);
  assign sample_stb = byp_on || ((emap == DRIVE_ON_RISE) ? fall_p : rise_p);

  a_r8_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !byp_on |-> !(drive_stb && sample_stb));

  a_r9_fall_after_high: assert property (@(posedge clk) disable iff (rst)
    (fall_p && !byp_on) |-> (!div_clk && $past(div_clk)));

endmodule

// File: tb/sim_sdclk_gen.sv
module sim_sdclk_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] div_val = 8'd0;
  logic bypass = 1'b0, pwr_save = 1'b0, clk_en = 1'b0, edge_sel = 1'b0, bus_busy = 1'b0;
  logic card_clk, drive_stb, sample_stb;

  int vectors = 0, fails = 0;
  bit done = 0, armed = 0, have_prev = 0, mon_div = 0;
  int exp_hi[$], exp_lo[$];
  string exp_tag[$];
  event rise_ev;

  always #10 clk = ~clk;

  sdclk_gen u0 (
    .clk(clk), .rst(rst), .div_val(div_val), .bypass(bypass), .pwr_save(pwr_save),
    .clk_en(clk_en), .edge_sel(edge_sel), .bus_busy(bus_busy),
    .card_clk(card_clk), .drive_stb(drive_stb), .sample_stb(sample_stb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: measures card clock phases and pops expected items.
  initial begin
    bit prev = 0, cur, rise, fall;
    int hi_c = 0, lo_c = 0;
    forever begin
      @(negedge clk); #1;
      if (rst) begin prev = 0; continue; end
      cur  = card_clk;
      rise = cur && !prev;
      fall = !cur && prev;
      if (mon_div) begin
        chk((edge_sel ? drive_stb : sample_stb) == rise, edge_sel ? "R8" : "R9",
            edge_sel ? drive_stb : sample_stb, rise);
        chk((edge_sel ? sample_stb : drive_stb) == fall, edge_sel ? "R8" : "R9",
            edge_sel ? sample_stb : drive_stb, fall);
      end
      if (rise) begin
        if (armed && have_prev && exp_hi.size() > 0) begin
          int eh, el; string t;
          eh = exp_hi.pop_front(); el = exp_lo.pop_front(); t = exp_tag.pop_front();
          chk(hi_c == eh, t, hi_c, eh);
          chk(lo_c == el, t, lo_c, el);
        end
        have_prev = armed;
        if (armed) ->rise_ev;
        hi_c = 1; lo_c = 0;
      end else if (cur) hi_c++;
      else lo_c++;
      prev = cur;
    end
  end

  task automatic push(input int d, input string t);
    exp_hi.push_back((d + 2) / 2);
    exp_lo.push_back((d + 2) - (d + 2) / 2);
    exp_tag.push_back(t);
  endtask

  task automatic drain();
    armed = 1;
    while (exp_hi.size() > 0) @(posedge clk);
    armed = 0; have_prev = 0;
    #2;
  endtask

  task automatic measure(input int d, input int n, input string t);
    div_val = 8'(d);
    repeat (2 * 257 + 6) @(posedge clk);
    #2;
    for (int i = 0; i < n; i++) push(d, t);
    drain();
  endtask

  task automatic quiet(input int n, input string t);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      chk(card_clk == 0, t, card_clk, 0);
      chk(!drive_stb && !sample_stb, t, drive_stb | sample_stb, 0);
    end
    @(posedge clk); #2;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(card_clk == 0 && !drive_stb && !sample_stb, "R1", card_clk, 0);
    @(posedge clk); #2;
    rst = 0;
    @(negedge clk); #1;
    chk(card_clk == 0 && !drive_stb && !sample_stb, "R1", card_clk, 0);
    @(posedge clk); #2;
    clk_en = 1; mon_div = 1;
    // R2 / R3: periods and phase lengths
    measure(0, 4, "R2");
    measure(1, 4, "R2");
    measure(2, 3, "R3");
    measure(5, 3, "R3");
    measure(255, 2, "R2");
    // R4: change in mid-period
    div_val = 8'd4;
    repeat (600) @(posedge clk); #2;
    push(4, "R4"); push(7, "R4");
    armed = 1;
    @(rise_ev);
    repeat (2) @(posedge clk); #2;
    div_val = 8'd7;
    drain();
    // R8: swapped edge map
    edge_sel = 1;
    measure(3, 3, "R8");
    edge_sel = 0;
    // R5: clock enable off
    clk_en = 0;
    repeat (300) @(posedge clk); #2;
    quiet(60, "R5");
    // R6: power save
    clk_en = 1; pwr_save = 1; bus_busy = 0;
    repeat (300) @(posedge clk); #2;
    quiet(60, "R6");
    bus_busy = 1;
    measure(3, 3, "R6");
    bus_busy = 0;
    repeat (300) @(posedge clk); #2;
    quiet(30, "R6");
    pwr_save = 0;
    measure(3, 2, "R6");
    // R7: bypass
    clk_en = 0;
    repeat (300) @(posedge clk); #2;
    mon_div = 0;
    bypass = 1; div_val = 8'd200; clk_en = 1;
    repeat (5) @(posedge clk);
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #5;
      chk(card_clk == 1, "R7", card_clk, 1);
      chk(drive_stb && sample_stb, "R7", drive_stb & sample_stb, 1);
      @(negedge clk); #5;
      chk(card_clk == 0, "R7", card_clk, 0);
    end
    @(posedge clk); #2;
    clk_en = 0;
    repeat (5) @(posedge clk); #2;
    quiet(10, "R7");
    bypass = 0; clk_en = 1;
    repeat (4) @(posedge clk); #2;
    mon_div = 1;
    measure(2, 2, "R7");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule